// File: doc/BRIEF.md
# Cascadable Binary Up Counter with Look-Ahead Carry

The block is a synchronous binary up counter, five bits wide by default. It has a synchronous clear, a synchronous parallel load and a count enable, all active high. It is meant to serve as one slice of a wider counter. Its carry output tells the next slice up that this slice holds its all-ones value.

In the default build the carry comes straight from a flip-flop. The value for that flip-flop is worked out one cycle early, from the control inputs of the edge being taken and the current count. The carry therefore reaches the next slice early in the cycle and does not wait on a decoder. A parameter can select instead a gate-built carry, which is the count enable ANDed with the all-ones decode of the count.

When slices are chained using the registered carry, the integrator must form each upper slice's enable outside the block. That enable is the master enable ANDed with the carries of every lower slice. No stream data passes through the block, so all its pins are plain control and status signals with no valid/ready handshake.

Top module: `cac_counter`

## Requirements
- R1: While `rst_n` is low, and at the first sampling after its release, `count_o` is 0 and `carry_o` is 0.
- R2: When `clr_i` is 1 at a rising edge, `count_o` becomes 0 and `carry_o` becomes 0, whatever `ld_i`, `en_i` and `ld_data_i` are.
- R3: When `clr_i` is 0 and `ld_i` is 1 at an edge, `count_o` takes `ld_data_i`, whatever `en_i` is.
- R4: When `clr_i` and `ld_i` are 0, an edge with `en_i`=1 raises `count_o` by one modulo 2^WIDTH. An edge with `en_i`=0 leaves `count_o` unchanged.
- R5: With the registered carry (REG_CARRY=1), `carry_o` is 1 in exactly those cycles in which `count_o` is all ones (31 for WIDTH=5). This holds when that value is reached by counting from 30 and when it is held with `en_i`=0.
- R6: With the registered carry, `carry_o` is 0 in the cycle after the count wraps from all ones to 0.
- R7: With REG_CARRY=0, `carry_o` equals `en_i` AND (`count_o` is all ones), in the same cycle with no register delay.
- R8: Two registered-carry slices, where the upper enable is the master enable AND the lower `carry_o`, form a 10-bit counter that steps through 1023 to 0 with no lost or extra step.
- R9: With the registered carry, a load of the all-ones value gives `carry_o`=1 in the cycle right after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear, highest priority |
| ld_i | input | 1 | Synchronous parallel load |
| en_i | input | 1 | Count enable |
| ld_data_i | input | WIDTH | Value taken on a load |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Carry to the next slice (registered or gate-built, per REG_CARRY) |

## Verification
The registered and the gate-built variants are driven side by side. The stimulus is a long pseudo-random mix of clear, load and enable, with clear and load rare so that long count runs occur. That mix separates the priority order and shows whether the look-ahead carry ever drifts from the terminal-count decode. Loads of every value, each followed by counting and holding, show which look-ahead term is at fault: the count-into-all-ones term, the hold-at-all-ones term, the load-of-all-ones term, or the wrap. A 10-bit chain of two slices is loaded near the top and run past 1023, which shows whether the carry arrives in the right cycle for the upper slice.

// File: rtl/cac_pkg.sv
package cac_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } cac_act_e;
endpackage

// File: rtl/cac_ctl.sv
module cac_ctl
  import cac_pkg::*;
(
  input  logic     clr_i,
  input  logic     ld_i,
  input  logic     en_i,
  output cac_act_e act_o
);
  always_comb begin
    if (clr_i)     act_o = ACT_CLEAR;
    else if (ld_i) act_o = ACT_LOAD;
    else if (en_i) act_o = ACT_COUNT;
    else           act_o = ACT_HOLD;
  end

  always_comb begin
    if (clr_i) assert (act_o == ACT_CLEAR) else $error("p_clear_wins_r2");
  end
endmodule

// File: rtl/cac_next.sv
module cac_next
  import cac_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  cac_act_e          act_i,
  input  logic [WIDTH-1:0]  cur_i,
  input  logic [WIDTH-1:0]  ld_data_i,
  output logic [WIDTH-1:0]  nxt_o
);
  always_comb begin
    unique case (act_i)
      ACT_CLEAR: nxt_o = '0;
      ACT_LOAD:  nxt_o = ld_data_i;
      ACT_COUNT: nxt_o = cur_i + WIDTH'(1);
      default:   nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/cac_carry_ahead.sv
module cac_carry_ahead
  import cac_pkg::*;
#(
  parameter int WIDTH = 5
) (
  input  cac_act_e          act_i,
  input  logic [WIDTH-1:0]  cur_i,
  input  logic [WIDTH-1:0]  ld_data_i,
  output logic              carry_nxt_o
);
  localparam logic [WIDTH-1:0] TOP     = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] PRE_TOP = TOP - WIDTH'(1);

  always_comb begin
    unique case (act_i)
      ACT_CLEAR: carry_nxt_o = 1'b0;
      ACT_LOAD:  carry_nxt_o = (ld_data_i == TOP);
      ACT_COUNT: carry_nxt_o = (cur_i == PRE_TOP);
      default:   carry_nxt_o = (cur_i == TOP);
    endcase
  end
endmodule

// File: rtl/cac_counter.sv
module cac_counter
  import cac_pkg::*;
#(
  parameter int WIDTH     = 5,
  parameter bit REG_CARRY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] ld_data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  cac_act_e         act;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;

  cac_ctl u_ctl (
    .clr_i (clr_i),
    .ld_i  (ld_i),
    .en_i  (en_i),
    .act_o (act)
  );

  cac_next #(.WIDTH(WIDTH)) u_next (
    .act_i     (act),
    .cur_i     (cnt_q),
    .ld_data_i (ld_data_i),
    .nxt_o     (cnt_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign count_o = cnt_q;

  generate
    if (REG_CARRY) begin : g_reg_carry
      logic carry_nxt;
      logic carry_q;

      cac_carry_ahead #(.WIDTH(WIDTH)) u_ahead (
        .act_i       (act),
        .cur_i       (cnt_q),
        .ld_data_i   (ld_data_i),
        .carry_nxt_o (carry_nxt)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= carry_nxt;
      end

      assign carry_o = carry_q;

      p_carry_tracks_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o == (count_o == TOP));
      p_load_top_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ld_i && ld_data_i == TOP) |=> carry_o);
      p_wrap_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !ld_i && en_i && count_o == TOP) |=> !carry_o);
    end else begin : g_comb_carry
      assign carry_o = en_i && (cnt_q == TOP);
    end
  endgenerate

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && ld_i) |=> (count_o == $past(ld_data_i)));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !ld_i && en_i) |=> (count_o == $past(count_o) + WIDTH'(1)));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !ld_i && !en_i) |=> $stable(count_o));
endmodule

// File: tb/cac_counter_tb_top.sv
`timescale 1ns/1ps
module cac_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       clr = 0, ld = 0, en = 0;
  logic [4:0] din = '0;
  logic [4:0] cnt_r, cnt_c;
  logic       cy_r, cy_c;

  cac_counter #(.WIDTH(5), .REG_CARRY(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .ld_i(ld), .en_i(en),
    .ld_data_i(din), .count_o(cnt_r), .carry_o(cy_r));

  cac_counter #(.WIDTH(5), .REG_CARRY(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .ld_i(ld), .en_i(en),
    .ld_data_i(din), .count_o(cnt_c), .carry_o(cy_c));

  // 10-bit chain for R8
  logic       kclr = 0, kld = 0, ken = 0;
  logic [9:0] kd = '0;
  logic [4:0] lo_q, hi_q;
  logic       lo_cy, hi_cy, hi_en;
  assign hi_en = ken & lo_cy;

  cac_counter #(.WIDTH(5), .REG_CARRY(1'b1)) dut_lo (
    .clk(clk), .rst_n(rst_n), .clr_i(kclr), .ld_i(kld), .en_i(ken),
    .ld_data_i(kd[4:0]), .count_o(lo_q), .carry_o(lo_cy));
  cac_counter #(.WIDTH(5), .REG_CARRY(1'b1)) dut_hi (
    .clk(clk), .rst_n(rst_n), .clr_i(kclr), .ld_i(kld), .en_i(hi_en),
    .ld_data_i(kd[9:5]), .count_o(hi_q), .carry_o(hi_cy));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [4:0] exp_cnt = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input logic c, input logic l, input logic e, input logic [4:0] dv);
    logic [4:0] nxt;
    string tg;
    clr = c; ld = l; en = e; din = dv;
    #1;
    chk(cy_c === (e && exp_cnt == 5'd31), "R7 comb carry", int'(cy_c), int'(e && exp_cnt == 5'd31));
    if (c)      begin nxt = '0;             tg = "R2 clear"; end
    else if (l) begin nxt = dv;             tg = "R3 load"; end
    else if (e) begin nxt = exp_cnt + 5'd1; tg = "R4 count"; end
    else        begin nxt = exp_cnt;        tg = "R4 hold"; end
    @(posedge clk);
    @(negedge clk);
    exp_cnt = nxt;
    chk(cnt_r === exp_cnt, tg, int'(cnt_r), int'(exp_cnt));
    chk(cnt_c === exp_cnt, tg, int'(cnt_c), int'(exp_cnt));
    if (c)                  chk(cy_r === 1'b0, "R2 clear carry", int'(cy_r), 0);
    else if (l && dv == 31) chk(cy_r === 1'b1, "R9 load top carry", int'(cy_r), 1);
    else if (exp_cnt == 0)  chk(cy_r === 1'b0, "R6 carry low at zero", int'(cy_r), 0);
    else chk(cy_r === (exp_cnt == 5'd31), "R5 carry tracks top", int'(cy_r), int'(exp_cnt == 5'd31));
  endtask

  task automatic kstep(input logic c, input logic l, input logic e, input logic [9:0] dv,
                       inout int model);
    kclr = c; kld = l; ken = e; kd = dv;
    @(posedge clk);
    @(negedge clk);
    if (c)      model = 0;
    else if (l) model = int'(dv);
    else if (e) model = (model + 1) % 1024;
    chk({hi_q, lo_q} === 10'(model), "R8 chain value", int'({hi_q, lo_q}), model);
  endtask

  initial begin
    logic [15:0] lfsr;
    int kmodel;
    repeat (3) @(negedge clk);
    chk(cnt_r === 5'd0 && cy_r === 1'b0, "R1 reset state", int'({cy_r, cnt_r}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cnt_r === 5'd0 && cy_r === 1'b0, "R1 after release", int'({cy_r, cnt_r}), 0);

    // Sweep: load every value, count a few, hold
    for (int v = 0; v < 32; v++) begin
      step(0, 1, v[0], 5'(v));
      step(0, 0, 1, 5'd0);
      step(0, 0, 0, 5'd0);
      step(0, 0, 1, 5'd0);
    end
    // Full run through the wrap, with holds at the top
    step(1, 1, 1, 5'd31);
    for (int i = 0; i < 31; i++) step(0, 0, 1, 5'd0);
    step(0, 0, 0, 5'd0);
    step(0, 0, 0, 5'd0);
    step(0, 0, 1, 5'd0);
    step(0, 0, 1, 5'd0);
    // Load priority over count, clear priority over load
    step(0, 1, 1, 5'd30);
    step(0, 1, 0, 5'd31);
    step(1, 1, 1, 5'd31);

    // Pseudo-random mix
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0] == 4'd0, lfsr[6:4] == 3'd0, lfsr[8:7] != 2'd0, lfsr[13:9]);
    end

    // Cascade R8
    kmodel = 0;
    kstep(1, 0, 0, 10'd0, kmodel);
    kstep(0, 1, 0, 10'd1018, kmodel);
    for (int i = 0; i < 80; i++) kstep(0, 0, 1, 10'd0, kmodel);
    kstep(0, 1, 0, 10'd1023, kmodel);
    kstep(0, 0, 0, 10'd0, kmodel);
    kstep(0, 0, 1, 10'd0, kmodel);
    kstep(0, 1, 1, 10'd991, kmodel);
    for (int i = 0; i < 40; i++) kstep(0, 0, (i % 3) != 0, 10'd0, kmodel);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule